// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This unit collects the interrupt sources of a UART and turns them into interrupt lines. Eleven sources feed a raw status register. They are the receive path (the FIFO level reaching its trigger, and a receive timeout), the transmit path (each data write), four error detectors and four modem-status pins. An eleven-bit enable mask is applied to the raw status. Six registered lines leave the block: one combined line and five lines that each cover a group of sources.

Software reaches the unit through a plain 32-bit register port with a two-bit word select. It writes the mask, reads the raw and masked status, and clears sources with a write-one-to-clear register. Events arrive as single-cycle pulses from the neighbouring datapaths. The receive FIFO supplies its current fill count and trigger level together with its push and pop strobes. The modem-pin sampler supplies an update strobe together with the pin levels. The port is a control port, so it has no valid/ready handshake. A write takes effect at the next clock edge, and a read returns the current contents in the same cycle.

Top module: `uart_irq_unit`

## Requirements
- R1: Source bits are: ring 0, clear-to-send 1, carrier detect 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. The lines of `irq_o` are: bit 0 any masked source; bit 1 receive; bit 2 transmit; bit 3 receive timeout; bit 4 any of bits 3..0; bit 5 any of bits 10..7.
- R2: Register select 2 reads the raw status ANDed with the mask. Select 1 reads the raw status without masking.
- R3: A write to select 3 (clear) clears every raw bit written as 1 and leaves the other raw bits unchanged.
- R4: Writes to select 1 and select 2 change nothing. Select 3 always reads as zero.
- R5: A write to select 0 replaces the whole mask with bits 10..0 of the write data. Select 0 reads the mask back.
- R6: A pulse on `tx_data_wr` sets raw bit 5.
- R7: A push while `rx_count + 1 == rx_trigger` sets raw bit 4. A pop while `rx_count == rx_trigger` (trigger non-zero) clears raw bit 4. In both cases `rx_count` is the count before the operation.
- R8: A `modem_upd` pulse sets raw bits 3..0 equal to `modem_pins[3:0]`, which overrides any clear written in the same cycle.
- R9: Reset clears the mask, the raw status and all six lines.
- R10: Read bits 31..11 are zero. Write bits 31..11 are ignored.
- R11: Each line reflects the raw status and mask as they stood one clock earlier.
- R12: When a set event and a clear write hit the same bit in one cycle, the bit ends up set.
- R13: `rx_timeout` sets bit 6. `err_ev[i]` sets bit 7+i, with 0 framing, 1 parity, 2 break and 3 overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, available in the same cycle |
| tx_data_wr | input | 1 | Pulse for each transmit data write |
| rx_push | input | 1 | Pulse for each receive FIFO push |
| rx_pop | input | 1 | Pulse for each receive data read |
| rx_count | input | CNT_W | Receive FIFO fill before this cycle's operation |
| rx_trigger | input | CNT_W | Receive trigger level |
| rx_timeout | input | 1 | Receive timeout pulse |
| err_ev | input | 4 | Error pulses: framing, parity, break, overrun |
| modem_upd | input | 1 | Modem flags updated this cycle |
| modem_pins | input | 4 | Modem flag levels: ring, CTS, DCD, DSR |
| irq_o | output | 6 | Combined, receive, transmit, timeout, modem, error lines |

## Verification
The assertions assume four things about the inputs. Event inputs are synchronous pulses. `modem_pins` is valid in any cycle where `modem_upd` is high. `rx_count` and `rx_trigger` describe the FIFO state before the operation of that cycle. At most one register write occurs per clock. The stimulus changes every input on the falling edge and drops pulses after a single cycle. It keeps `rx_trigger` inside the counter width. It issues reads only in cycles where the write strobe is low.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 11;
  localparam int NOUT   = 6;
  localparam int MS_LO  = 0;
  localparam int MS_W   = 4;
  localparam int B_RX   = 4;
  localparam int B_TX   = 5;
  localparam int B_RT   = 6;
  localparam int ERR_LO = 7;
  localparam int ERR_W  = 4;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_CLEAR  = 2'd3
  } reg_sel_e;

  // source bits covered by each output line
  function automatic logic [NSRC-1:0] line_group(input int idx);
    logic [NSRC-1:0] m;
    m = '0;
    case (idx)
      0: m = '1;
      1: m[B_RX] = 1'b1;
      2: m[B_TX] = 1'b1;
      3: m[B_RT] = 1'b1;
      4: m[MS_LO +: MS_W] = '1;
      default: m[ERR_LO +: ERR_W] = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/uart_irq_rx_track.sv
module uart_irq_rx_track #(
  parameter int CNT_W = 5
) (
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trigger,
  output logic             rx_set,
  output logic             rx_clr
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] count_next;
  logic             trig_nz;

  always_comb begin
    count_next = {1'b0, count} + EXT_W'(1);
    trig_nz    = |trigger;
    rx_set     = push && (count_next == {1'b0, trigger});
    rx_clr     = pop && trig_nz && (count == trigger);
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int W = NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     set_vec,
  input  logic [W-1:0]     clr_vec,
  input  logic             modem_upd,
  input  logic [MS_W-1:0]  modem_pins,
  output logic [W-1:0]     raw_o
);
  logic [W-1:0] raw_q;
  logic [W-1:0] kept;
  logic [W-1:0] raw_d;

  always_comb begin
    kept = raw_q & ~clr_vec;
    if (modem_upd) kept[MS_LO +: MS_W] = '0;
    raw_d = kept | set_vec;
    if (modem_upd) raw_d[MS_LO +: MS_W] = raw_d[MS_LO +: MS_W] | modem_pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
  import uart_irq_pkg::*;
#(
  parameter int W      = NSRC,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      raw_i,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e     sel;
  logic [W-1:0] mask_q;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_q <= '0;
    else if (wr_en && sel == SEL_MASK)   mask_q <= wdata[W-1:0];
  end

  always_comb begin
    clr_o = '0;
    if (wr_en && sel == SEL_CLEAR) clr_o = wdata[W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_MASK:   rdata_o[W-1:0] = mask_q;
      SEL_RAW:    rdata_o[W-1:0] = raw_i;
      SEL_MASKED: rdata_o[W-1:0] = raw_i & mask_q;
      default:    rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
  import uart_irq_pkg::*;
#(
  parameter int W = NSRC,
  parameter int N = NOUT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [N-1:0] irq_o
);
  logic [W-1:0] active;
  assign active = raw_i & mask_i;

  for (genvar g = 0; g < N; g++) begin : g_line
    localparam logic [W-1:0] GRP = line_group(g);
    logic line_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= |(active & GRP);
    end
    assign irq_o[g] = line_q;
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             tx_data_wr,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             rx_timeout,
  input  logic [3:0]       err_ev,
  input  logic             modem_upd,
  input  logic [3:0]       modem_pins,
  output logic [5:0]       irq_o
);
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] sw_clr;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic            rx_set;
  logic            rx_clr;

  uart_irq_rx_track #(.CNT_W(CNT_W)) u_rx (
    .push(rx_push), .pop(rx_pop), .count(rx_count), .trigger(rx_trigger),
    .rx_set(rx_set), .rx_clr(rx_clr)
  );

  always_comb begin
    set_vec = '0;
    set_vec[B_RX] = rx_set;
    set_vec[B_TX] = tx_data_wr;
    set_vec[B_RT] = rx_timeout;
    set_vec[ERR_LO +: ERR_W] = err_ev;
    clr_vec = sw_clr;
    clr_vec[B_RX] = sw_clr[B_RX] | rx_clr;
  end

  uart_irq_status #(.W(NSRC)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .modem_upd(modem_upd), .modem_pins(modem_pins), .raw_o(raw_q)
  );

  uart_irq_regif #(.W(NSRC), .DATA_W(32)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .raw_i(raw_q), .mask_o(mask_q), .clr_o(sw_clr),
    .rdata_o(reg_rdata)
  );

  uart_irq_lines #(.W(NSRC), .N(NOUT)) u_lines (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_q), .mask_i(mask_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        tx_data_wr,
  input logic [3:0]  err_ev,
  input logic        modem_upd,
  input logic [3:0]  modem_pins,
  input logic [10:0] raw,
  input logic [10:0] mask,
  input logic [5:0]  irq_o
);
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (irq_o == 6'b0));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:11] == 21'b0);

  assert_line_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] == $past(|(raw & mask)));

  assert_combined_covers_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o[5:1]) |-> irq_o[0]);

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd0) |=> (mask == $past(reg_wdata[10:0])));

  assert_tx_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_wr |=> raw[5]);

  assert_modem_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    modem_upd |=> (raw[3:0] == $past(modem_pins)));

  assert_error_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_ev) |=> ((raw[10:7] & $past(err_ev)) == $past(err_ev)));
endmodule

bind uart_irq_unit uart_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data_wr(tx_data_wr),
  .err_ev(err_ev), .modem_upd(modem_upd), .modem_pins(modem_pins),
  .raw(raw_q), .mask(mask_q), .irq_o(irq_o)
);

// File: tb/sim_uart_irq_unit.sv
`timescale 1ns/1ps
module sim_uart_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_data_wr = 1'b0;
  logic        rx_push = 1'b0;
  logic        rx_pop = 1'b0;
  logic [4:0]  rx_count = '0;
  logic [4:0]  rx_trigger = 5'd4;
  logic        rx_timeout = 1'b0;
  logic [3:0]  err_ev = '0;
  logic        modem_upd = 1'b0;
  logic [3:0]  modem_pins = '0;
  logic [5:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_unit #(.CNT_W(5)) u0 (.*);

  // behavioural reference
  int m_raw = 0, m_mask = 0, m_irq = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = 0; m_mask = 0; m_irq = 0;
    end else begin
      int act, clr, nxt;
      act = m_raw & m_mask;
      m_irq = ((act != 0) ? 1 : 0) | (((act >> 4) & 1) << 1) | (((act >> 5) & 1) << 2)
            | (((act >> 6) & 1) << 3) | (((act & 'hF) != 0) ? 16 : 0)
            | (((act & 'h780) != 0) ? 32 : 0);
      clr = (reg_wr_en && reg_addr == 3) ? (reg_wdata & 'h7FF) : 0;
      if (rx_pop && rx_trigger != 0 && rx_count == rx_trigger) clr = clr | 'h10;
      if (modem_upd) clr = clr | 'hF;
      nxt = m_raw & ~clr;
      if (tx_data_wr) nxt = nxt | 'h20;
      if (rx_timeout) nxt = nxt | 'h40;
      nxt = nxt | (int'(err_ev) << 7);
      if (rx_push && int'(rx_count) + 1 == int'(rx_trigger)) nxt = nxt | 'h10;
      if (modem_upd) nxt = nxt | int'(modem_pins);
      if (reg_wr_en && reg_addr == 0) m_mask = reg_wdata & 'h7FF;
      m_raw = nxt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    reg_wr_en = 0; tx_data_wr = 0; rx_push = 0; rx_pop = 0;
    rx_timeout = 0; err_ev = '0; modem_upd = 0;
  endtask

  // one clock; compare the lines every cycle (R1, R11)
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R1 R11 irq lines", int'(irq_o), m_irq);
    quiet();
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 lines in reset", int'(irq_o), 0);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, 0, "R9 mask after reset");
    rd(2'd1, 0, "R9 raw after reset");

    // R5 R10: full write, only low 11 bits kept
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 'h7FF, "R5 R10 mask readback");

    // R6 transmit
    tx_data_wr = 1; tick();
    rd(2'd1, 'h20, "R6 tx raw bit");
    tick();
    chk("R1 transmit line", int'(irq_o), 'b000101);

    // R3 clear only written bits
    err_ev = 4'b0101; tick();
    wr(2'd3, 32'h0000_0080);
    rd(2'd1, 'h220, "R3 partial clear");

    // R13 timeout and errors
    rx_timeout = 1; err_ev = 4'b1010; tick();
    rd(2'd1, 'h760, "R13 timeout and error bits");

    // R4 ignored writes
    wr(2'd1, 32'h0000_0000);
    wr(2'd2, 32'h0000_07FF);
    rd(2'd1, 'h760, "R4 raw unchanged");
    rd(2'd3, 0, "R4 clear reads zero");

    // R5 R2 mask replace and masked view
    wr(2'd0, 32'hFFFF_F840);
    rd(2'd0, 'h040, "R5 mask replaced");
    rd(2'd2, 'h040, "R2 masked view");
    rd(2'd1, 'h760, "R2 raw unmasked");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, 0, "R3 R10 clear all");
    wr(2'd0, 32'h7FF);

    // R7 receive trigger
    rx_push = 1; rx_count = 5'd2; tick();
    rd(2'd1, 0, "R7 push below trigger");
    rx_push = 1; rx_count = 5'd3; tick();
    rd(2'd1, 'h10, "R7 push reaches trigger");
    rx_pop = 1; rx_count = 5'd5; tick();
    rd(2'd1, 'h10, "R7 pop above trigger keeps");
    rx_pop = 1; rx_count = 5'd4; tick();
    rd(2'd1, 0, "R7 pop from trigger clears");

    // R8 modem recompute
    modem_upd = 1; modem_pins = 4'b0101; tick();
    rd(2'd1, 'h5, "R8 modem pins 0101");
    modem_upd = 1; modem_pins = 4'b1010; tick();
    rd(2'd1, 'hA, "R8 modem pins 1010");
    reg_wr_en = 1; reg_addr = 2'd3; reg_wdata = 32'hF;
    modem_upd = 1; modem_pins = 4'b0011; tick();
    rd(2'd1, 'h3, "R8 pins beat clear");

    // R12 set beats clear
    reg_wr_en = 1; reg_addr = 2'd3; reg_wdata = 32'h7FF;
    err_ev = 4'b1000; tx_data_wr = 1; tick();
    rd(2'd1, 'h420, "R12 set wins over clear");
    tick();
    chk("R1 error and transmit lines", int'(irq_o), 'b100101);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      tx_data_wr = r[0];
      rx_push = r[1]; rx_pop = r[2];
      rx_count = 5'(r[5:3]);
      rx_timeout = r[6] & r[7];
      err_ev = r[11:8] & {4{r[12]}};
      modem_upd = r[13];
      modem_pins = r[17:14];
      reg_wr_en = r[18] & r[19];
      reg_addr = r[21:20];
      reg_wdata = $urandom;
      tick();
      rd(2'd1, m_raw, "R2 R3 R12 raw vs model");
      rd(2'd2, m_raw & m_mask, "R2 masked vs model");
    end

    rst_n = 0;
    @(negedge clk);
    chk("R9 lines after reset", int'(irq_o), 0);
    rd(2'd1, 0, "R9 raw after reset");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule